// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the host-facing register file of a PC-style serial port. A host issues single-cycle read or write strobes with a 3-bit offset and an 8-bit data byte. The block decodes the offset, keeps the control registers that belong to the port, and returns read data one cycle after the read strobe. The serializer, receive path, FIFOs and interrupt prioritisation sit outside the block. They supply the received byte, the interrupt identification byte, the line and modem status bytes and a raw interrupt request. The block returns the transmit byte, the FIFO control byte, the control register contents, the 16-bit baud divisor and single-cycle event pulses.

The same offset can mean different registers. Whether a strobe is a read or a write matters, and so does a divisor-access bit held in line control. When that bit is set, the two lowest offsets reach the baud divisor instead of the data and interrupt-enable registers. The interrupt pin is the raw request masked by a general-purpose output bit of modem control. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, line control, interrupt enable, modem control, scratch, divisor and read data are all zero. The interrupt output is low even if the raw request is high.
- R2: With the divisor-access bit (line control bit 7) clear, a read at offset 0 returns `rx_data`. `rx_consume` is high for exactly the one cycle after the read strobe.
- R3: With bit 7 clear, a write at offset 0 places the byte on `thr_data`. `thr_load` pulses high for the one cycle after the strobe. No stored register changes.
- R4: With bit 7 clear, offset 1 reads and writes the interrupt-enable register, and its value is shown on `ier`.
- R5: With bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes, shown on `divisor`. Neither `thr_load` nor `rx_consume` fires for those accesses.
- R6: Offset 2 reads return `iir_in`. Offset 2 writes copy the byte to `fcr_data` and pulse `fcr_write` for one cycle. Both hold for either state of bit 7.
- R7: Offset 3 reads and writes line control, and bit 7 of line control is the divisor-access bit.
- R8: Offset 4 reads and writes modem control. Offsets 5 and 6 read `lsr_in` and `msr_in`. Writes to offsets 5 and 6 change no register and fire no pulse.
- R9: Offset 7 stores any byte and returns it, with no pulse and no other register changed.
- R10: `irq` equals `irq_req` AND modem control bit 3.
- R11: `rdata` changes only on the cycle after a read strobe. When a read and a write hit the same offset in one cycle, the read returns the value from before the write and uses the old divisor-access bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Received byte from receiver |
| iir_in | input | 8 | Interrupt identification byte |
| lsr_in | input | 8 | Line status byte |
| msr_in | input | 8 | Modem status byte |
| irq_req | input | 1 | Raw interrupt request |
| thr_data | output | 8 | Byte for the transmitter |
| thr_load | output | 1 | Transmit load pulse |
| rx_consume | output | 1 | Receive data consumed pulse |
| fcr_data | output | 8 | Last FIFO control byte |
| fcr_write | output | 1 | FIFO control write pulse |
| ier | output | 8 | Interrupt enable register |
| lcr | output | 8 | Line control register |
| mcr | output | 8 | Modem control register |
| divisor | output | 16 | Baud divisor |
| irq | output | 1 | Gated interrupt |

## Verification
Since read and write strobes share one offset, the two functions that can land in the same cycle are a read and a write of the same register. The bench raises both strobes together at offset 3 while the write sets the divisor-access bit. The read must return the old line control value, and a following read at offset 0 must see the divisor low byte. It also raises both strobes at offset 0 with the bit clear. The scoreboard then requires the received byte on `rdata` and requires `rx_consume` and `thr_load` to pulse in the same cycle.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  localparam int DW       = 8;
  localparam int AW       = 3;
  localparam int DIV_W    = 2 * DW;
  localparam int DLAB_BIT = 7;
  localparam int OUT2_BIT = 3;

  typedef enum logic [AW-1:0] {
    OFS_DATA = 3'd0,
    OFS_IER  = 3'd1,
    OFS_IIR  = 3'd2,
    OFS_LCR  = 3'd3,
    OFS_MCR  = 3'd4,
    OFS_LSR  = 3'd5,
    OFS_MSR  = 3'd6,
    OFS_SCR  = 3'd7
  } ofs_e;

  typedef struct packed {
    logic thr;
    logic fcr;
    logic ier;
    logic lcr;
    logic mcr;
    logic scr;
    logic dll;
    logic dlm;
  } wstb_t;
endpackage

// File: rtl/uart_host_decode.sv
module uart_host_decode
  import uart_host_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          dlab,
  output wstb_t         wstb,
  output logic          rbr_rd
);
  logic at_data, at_ier, at_iir, at_lcr, at_mcr, at_scr;

  always_comb begin
    at_data = (addr == OFS_DATA);
    at_ier  = (addr == OFS_IER);
    at_iir  = (addr == OFS_IIR);
    at_lcr  = (addr == OFS_LCR);
    at_mcr  = (addr == OFS_MCR);
    at_scr  = (addr == OFS_SCR);

    wstb.thr = wr & at_data & ~dlab;
    wstb.dll = wr & at_data &  dlab;
    wstb.ier = wr & at_ier  & ~dlab;
    wstb.dlm = wr & at_ier  &  dlab;
    wstb.fcr = wr & at_iir;
    wstb.lcr = wr & at_lcr;
    wstb.mcr = wr & at_mcr;
    wstb.scr = wr & at_scr;
    rbr_rd   = rd & at_data & ~dlab;
  end
endmodule

// File: rtl/uart_host_store.sv
module uart_host_store
  import uart_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  wstb_t         wstb,
  input  logic          rbr_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ier,
  output logic [DW-1:0] lcr,
  output logic [DW-1:0] mcr,
  output logic [DW-1:0] scr,
  output logic [DW-1:0] dll,
  output logic [DW-1:0] dlm,
  output logic [DW-1:0] thr_data,
  output logic          thr_load,
  output logic [DW-1:0] fcr_data,
  output logic          fcr_write,
  output logic          rx_consume
);
  logic [DW-1:0] ier_d, lcr_d, mcr_d, scr_d, dll_d, dlm_d, thr_d, fcr_d;

  always_comb begin
    ier_d = wstb.ier ? wdata : ier;
    lcr_d = wstb.lcr ? wdata : lcr;
    mcr_d = wstb.mcr ? wdata : mcr;
    scr_d = wstb.scr ? wdata : scr;
    dll_d = wstb.dll ? wdata : dll;
    dlm_d = wstb.dlm ? wdata : dlm;
    thr_d = wstb.thr ? wdata : thr_data;
    fcr_d = wstb.fcr ? wdata : fcr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier        <= '0;
      lcr        <= '0;
      mcr        <= '0;
      scr        <= '0;
      dll        <= '0;
      dlm        <= '0;
      thr_data   <= '0;
      fcr_data   <= '0;
      thr_load   <= 1'b0;
      fcr_write  <= 1'b0;
      rx_consume <= 1'b0;
    end else begin
      ier        <= ier_d;
      lcr        <= lcr_d;
      mcr        <= mcr_d;
      scr        <= scr_d;
      dll        <= dll_d;
      dlm        <= dlm_d;
      thr_data   <= thr_d;
      fcr_data   <= fcr_d;
      thr_load   <= wstb.thr;
      fcr_write  <= wstb.fcr;
      rx_consume <= rbr_rd;
    end
  end

  a_r7_lcr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wstb.lcr |=> $stable(lcr));
  a_r9_scr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wstb.scr |=> $stable(scr));
  a_r3_thr_byte: assert property (@(posedge clk) disable iff (!rst_n)
    thr_load |-> (thr_data == $past(wdata)));
  a_r6_fcr_byte: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_write |-> (fcr_data == $past(wdata)));
endmodule

// File: rtl/uart_host_rdmux.sv
module uart_host_rdmux
  import uart_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic [DW-1:0] rx_data,
  input  logic [DW-1:0] iir_in,
  input  logic [DW-1:0] lsr_in,
  input  logic [DW-1:0] msr_in,
  input  logic [DW-1:0] ier,
  input  logic [DW-1:0] lcr,
  input  logic [DW-1:0] mcr,
  input  logic [DW-1:0] scr,
  input  logic [DW-1:0] dll,
  input  logic [DW-1:0] dlm,
  output logic [DW-1:0] rdata
);
  logic          dlab;
  logic [DW-1:0] sel_d;
  logic [DW-1:0] rdata_d;

  always_comb begin
    dlab = lcr[DLAB_BIT];
    unique case (ofs_e'(addr))
      OFS_DATA: sel_d = dlab ? dll : rx_data;
      OFS_IER:  sel_d = dlab ? dlm : ier;
      OFS_IIR:  sel_d = iir_in;
      OFS_LCR:  sel_d = lcr;
      OFS_MCR:  sel_d = mcr;
      OFS_LSR:  sel_d = lsr_in;
      OFS_MSR:  sel_d = msr_in;
      default:  sel_d = scr;
    endcase
    rdata_d = rd ? sel_d : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [DW-1:0]    rx_data,
  input  logic [DW-1:0]    iir_in,
  input  logic [DW-1:0]    lsr_in,
  input  logic [DW-1:0]    msr_in,
  input  logic             irq_req,
  output logic [DW-1:0]    thr_data,
  output logic             thr_load,
  output logic             rx_consume,
  output logic [DW-1:0]    fcr_data,
  output logic             fcr_write,
  output logic [DW-1:0]    ier,
  output logic [DW-1:0]    lcr,
  output logic [DW-1:0]    mcr,
  output logic [DIV_W-1:0] divisor,
  output logic             irq
);
  logic [1:0]    rst_pipe;
  logic          rst_n_s;
  wstb_t         wstb;
  logic          rbr_rd;
  logic [DW-1:0] scr, dll, dlm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  uart_host_decode u_dec (
    .addr   (addr),
    .rd     (rd),
    .wr     (wr),
    .dlab   (lcr[DLAB_BIT]),
    .wstb   (wstb),
    .rbr_rd (rbr_rd)
  );

  uart_host_store u_store (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wstb       (wstb),
    .rbr_rd     (rbr_rd),
    .wdata      (wdata),
    .ier        (ier),
    .lcr        (lcr),
    .mcr        (mcr),
    .scr        (scr),
    .dll        (dll),
    .dlm        (dlm),
    .thr_data   (thr_data),
    .thr_load   (thr_load),
    .fcr_data   (fcr_data),
    .fcr_write  (fcr_write),
    .rx_consume (rx_consume)
  );

  uart_host_rdmux u_rd (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .addr    (addr),
    .rd      (rd),
    .rx_data (rx_data),
    .iir_in  (iir_in),
    .lsr_in  (lsr_in),
    .msr_in  (msr_in),
    .ier     (ier),
    .lcr     (lcr),
    .mcr     (mcr),
    .scr     (scr),
    .dll     (dll),
    .dlm     (dlm),
    .rdata   (rdata)
  );

  assign divisor = {dlm, dll};
  assign irq     = irq_req & mcr[OUT2_BIT];

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mcr[OUT2_BIT] |-> !irq);
  a_r5_no_consume_dlab: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_consume |-> !$past(lcr[DLAB_BIT]));
  a_r5_no_load_dlab: assert property (@(posedge clk) disable iff (!rst_n_s)
    thr_load |-> !$past(lcr[DLAB_BIT]));
  a_r2_consume_from_read: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_consume |-> $past(rd && addr == 3'd0));
endmodule

// File: tb/sim_uart_host_regs.sv
module sim_uart_host_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  rx_data = 8'hA5, iir_in = 8'hC1, lsr_in = 8'h60, msr_in = 8'hB0;
  logic        irq_req = 1'b1;
  logic [7:0]  thr_data, fcr_data, ier, lcr, mcr;
  logic        thr_load, rx_consume, fcr_write, irq;
  logic [15:0] divisor;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  uart_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .rx_data(rx_data), .iir_in(iir_in), .lsr_in(lsr_in),
    .msr_in(msr_in), .irq_req(irq_req), .thr_data(thr_data), .thr_load(thr_load),
    .rx_consume(rx_consume), .fcr_data(fcr_data), .fcr_write(fcr_write),
    .ier(ier), .lcr(lcr), .mcr(mcr), .divisor(divisor), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected read result per read strobe
  always @(posedge clk) rd_q <= rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) check("R11 unexpected read", 16'(rdata), 16'hxxxx);
      else check(tag_q.pop_front(), 16'(rdata), 16'(exp_q.pop_front()));
    end
  end

  // driver: one access, then checks the pulses seen the cycle after
  task automatic access(input bit r, input bit w, input logic [2:0] a,
                        input logic [7:0] d, input logic [7:0] exp, input string tag,
                        input bit e_thr, input bit e_fcr, input bit e_rx);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d;
    if (r) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    check({tag, " thr_load"},   16'(thr_load),   16'(e_thr));
    check({tag, " fcr_write"},  16'(fcr_write),  16'(e_fcr));
    check({tag, " rx_consume"}, 16'(rx_consume), 16'(e_rx));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, R10 gate with irq_req high
    check("R1 lcr", 16'(lcr), 16'h0);
    check("R1 ier", 16'(ier), 16'h0);
    check("R1 mcr", 16'(mcr), 16'h0);
    check("R1 divisor", divisor, 16'h0);
    check("R1 rdata", 16'(rdata), 16'h0);
    check("R1 irq", 16'(irq), 16'h0);
    access(1, 0, 3'd7, 8'h00, 8'h00, "R1 scratch reset", 0, 0, 0);

    // R2 read receive buffer
    access(1, 0, 3'd0, 8'h00, 8'hA5, "R2 rbr read", 0, 0, 1);
    @(negedge clk);
    check("R2 consume single cycle", 16'(rx_consume), 16'h0);
    // R3 transmit write
    access(0, 1, 3'd0, 8'h3C, 8'h00, "R3 thr write", 1, 0, 0);
    check("R3 thr_data", 16'(thr_data), 16'h3C);
    check("R3 ier untouched", 16'(ier), 16'h0);
    // R4 interrupt enable
    access(0, 1, 3'd1, 8'h0F, 8'h00, "R4 ier write", 0, 0, 0);
    access(1, 0, 3'd1, 8'h00, 8'h0F, "R4 ier read", 0, 0, 0);
    check("R4 ier port", 16'(ier), 16'h0F);
    // R7 line control with access bit
    access(0, 1, 3'd3, 8'h83, 8'h00, "R7 lcr write", 0, 0, 0);
    access(1, 0, 3'd3, 8'h00, 8'h83, "R7 lcr read", 0, 0, 0);
    check("R7 lcr port", 16'(lcr), 16'h83);
    // R5 divisor access
    access(0, 1, 3'd0, 8'h34, 8'h00, "R5 dll write", 0, 0, 0);
    access(0, 1, 3'd1, 8'h12, 8'h00, "R5 dlm write", 0, 0, 0);
    check("R5 divisor", divisor, 16'h1234);
    check("R5 ier kept", 16'(ier), 16'h0F);
    check("R5 thr kept", 16'(thr_data), 16'h3C);
    access(1, 0, 3'd0, 8'h00, 8'h34, "R5 dll read", 0, 0, 0);
    access(1, 0, 3'd1, 8'h00, 8'h12, "R5 dlm read", 0, 0, 0);
    // R6 FIFO control / id with access bit set then clear
    access(0, 1, 3'd2, 8'hC7, 8'h00, "R6 fcr write dlab1", 0, 1, 0);
    check("R6 fcr_data", 16'(fcr_data), 16'hC7);
    access(1, 0, 3'd2, 8'h00, 8'hC1, "R6 iir read dlab1", 0, 0, 0);
    access(0, 1, 3'd3, 8'h03, 8'h00, "R7 lcr clear dlab", 0, 0, 0);
    access(0, 1, 3'd2, 8'h01, 8'h00, "R6 fcr write dlab0", 0, 1, 0);
    check("R6 fcr_data dlab0", 16'(fcr_data), 16'h01);
    iir_in = 8'hC4;
    access(1, 0, 3'd2, 8'h00, 8'hC4, "R6 iir read dlab0", 0, 0, 0);
    // R9 scratch
    access(0, 1, 3'd7, 8'h5A, 8'h00, "R9 scr write", 0, 0, 0);
    access(1, 0, 3'd7, 8'h00, 8'h5A, "R9 scr read", 0, 0, 0);
    check("R9 lcr kept", 16'(lcr), 16'h03);
    // R8 modem control and status
    access(0, 1, 3'd4, 8'h01, 8'h00, "R8 mcr write", 0, 0, 0);
    access(1, 0, 3'd4, 8'h00, 8'h01, "R8 mcr read", 0, 0, 0);
    access(1, 0, 3'd5, 8'h00, 8'h60, "R8 lsr read", 0, 0, 0);
    access(1, 0, 3'd6, 8'h00, 8'hB0, "R8 msr read", 0, 0, 0);
    access(0, 1, 3'd5, 8'hFF, 8'h00, "R8 lsr write ignored", 0, 0, 0);
    access(0, 1, 3'd6, 8'hFF, 8'h00, "R8 msr write ignored", 0, 0, 0);
    access(1, 0, 3'd5, 8'h00, 8'h60, "R8 lsr after write", 0, 0, 0);
    access(1, 0, 3'd4, 8'h00, 8'h01, "R8 mcr after write", 0, 0, 0);
    access(1, 0, 3'd7, 8'h00, 8'h5A, "R8 scr after write", 0, 0, 0);
    check("R8 lcr kept", 16'(lcr), 16'h03);
    check("R8 ier kept", 16'(ier), 16'h0F);
    check("R8 divisor kept", divisor, 16'h1234);
    // R10 interrupt gate (OUT2 = mcr bit 3)
    check("R10 irq masked", 16'(irq), 16'h0);
    access(0, 1, 3'd4, 8'h08, 8'h00, "R10 set out2", 0, 0, 0);
    #1 check("R10 irq passes", 16'(irq), 16'h1);
    irq_req = 1'b0;
    #1 check("R10 irq follows req", 16'(irq), 16'h0);
    // R11 hold and same-cycle read/write
    repeat (2) @(negedge clk);
    check("R11 rdata hold", 16'(rdata), 16'h5A);
    rx_data = 8'h77;
    access(1, 1, 3'd0, 8'h9E, 8'h77, "R11 rbr+thr same cycle", 1, 0, 1);
    check("R11 thr_data", 16'(thr_data), 16'h9E);
    access(1, 1, 3'd3, 8'h80, 8'h03, "R11 lcr old value", 0, 0, 0);
    access(1, 0, 3'd0, 8'h00, 8'h34, "R11 new dlab on next read", 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R11 queue drained", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule